// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns one IEEE-754 binary32 or binary64 operand into a signed two's-complement integer of 32 or 64 bits. Each request picks one of four rounding behaviours: nearest with ties to even, toward zero, toward plus infinity or toward minus infinity. The selected behaviour applies to that request alone and does not depend on any other rounding setting in the chip.

A request is a single-cycle strobe carrying the operand, a source format select, a destination width select and the rounding mode. One cycle later the unit presents the integer together with three cause flags (overflow, invalid, inexact) and a done pulse. The unit does not accumulate flags and does not trap. When the conversion is invalid or overflows, the integer is replaced by the largest positive value of the destination width. This applies to every such input, including NaN, negative infinity and negative overflow. Collecting flags into a status register is left to the surrounding pipeline.

Top module: `fcvt_unit`

## Requirements
- R1: Mode code 0 rounds to the nearest integer, and an exact half goes to the even neighbour.
- R2: Mode code 1 discards the fraction, rounding toward zero.
- R3: Mode code 2 rounds toward plus infinity.
- R4: Mode code 3 rounds toward minus infinity.
- R5: With in_is_double=1, in_operand[63:0] is read as binary64. With in_is_double=0, in_operand[31:0] is read as binary32 and in_operand[63:32] is ignored. With in_to_long=1, out_result is a 64-bit integer. With in_to_long=0, out_result holds a 32-bit integer sign-extended to 64 bits.
- R6: A NaN or infinite operand of either sign raises out_invalid and yields the positive default of the destination width.
- R7: A finite operand whose rounded value lies outside the destination range raises out_overflow and yields 64'h7FFFFFFF for a 32-bit destination or 64'h7FFFFFFFFFFFFFFF for a 64-bit destination, negative side included. A rounded value of exactly -2^31 or -2^63 still fits its width.
- R8: out_inexact is 1 exactly when the rounded integer differs from the operand and neither out_overflow nor out_invalid is raised.
- R9: out_done is 1 in the cycle after in_valid and 0 otherwise. Result and flags keep their values while in_valid is low.
- R10: Positive or negative zero gives 0 with no flag. A subnormal gives 0 with out_inexact, except that rounding up a positive subnormal gives 1 and rounding down a negative subnormal gives -1, both inexact.
- R11: After reset, out_done, out_result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Raw floating-point bits |
| in_is_double | input | 1 | 1: binary64, 0: binary32 in low half |
| in_to_long | input | 1 | 1: 64-bit result, 0: 32-bit result |
| in_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 up, 3 down |
| out_result | output | 64 | Converted integer |
| out_overflow | output | 1 | Range exceeded |
| out_invalid | output | 1 | NaN or infinity operand |
| out_inexact | output | 1 | Rounded value differs from operand |
| out_done | output | 1 | Result valid strobe |

## Verification
The bench sweeps every quarter-step value from -16 to +16 through all four modes, both source formats and both widths. This catches a tie rule that rounds halves away from zero, or a ceiling and floor that ignore the sign. It then targets the range edges: 2^31-0.5 under nearest-even must overflow, while -2^31-0.5 must not. A design that checks only the magnitude before rounding, or that uses a symmetric limit, fails these. It also probes subnormals under the directed modes, which a design that flushes them silently to zero gets wrong, and NaN or negative infinity, which a sign-saturating design turns into the minimum integer instead of the positive default.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int SIG_W     = 53;
  localparam int SIG_POINT = SIG_W - 1;
  localparam int INT_W     = 64;
  localparam int WORD_W    = 32;
  localparam int EXP_W     = 13;
  localparam int N_FMT     = 2;
  localparam int SGL_EXP   = 8;
  localparam int SGL_FRAC  = 23;
  localparam int DBL_EXP   = 11;
  localparam int DBL_FRAC  = 52;
  localparam logic signed [EXP_W-1:0] EXP_TINY = -13'sd1200;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic                    sign;
    logic                    special;
    logic                    nonzero;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unpacked_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
#(
  parameter int EXP_BITS  = 8,
  parameter int FRAC_BITS = 23
) (
  input  logic [EXP_BITS+FRAC_BITS:0] bits_i,
  output unpacked_t                   unp_o
);
  localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;
  localparam int PAD  = SIG_W - 1 - FRAC_BITS;

  logic [EXP_BITS-1:0]  efield;
  logic [FRAC_BITS-1:0] frac;
  logic [SIG_W-1:0]     sig_base;

  always_comb begin
    efield   = bits_i[FRAC_BITS +: EXP_BITS];
    frac     = bits_i[FRAC_BITS-1:0];
    sig_base = SIG_W'({1'b1, frac});
    unp_o.sign    = bits_i[EXP_BITS+FRAC_BITS];
    unp_o.special = &efield;
    unp_o.nonzero = |bits_i[EXP_BITS+FRAC_BITS-1:0];
    if (efield == '0) begin
      unp_o.exp = EXP_TINY;
    end else begin
      unp_o.exp = $signed(EXP_W'(efield)) - $signed(EXP_W'(BIAS));
    end
    unp_o.sig = sig_base << PAD;
  end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
  import fcvt_pkg::*;
(
  input  unpacked_t        unp_i,
  output logic [INT_W-1:0] int_o,
  output logic             rnd_o,
  output logic             stk_o,
  output logic             too_big_o
);
  localparam int WIDE_W = 2 * INT_W;

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] shifted;
  logic              tiny;
  int                e_i;

  always_comb begin
    wide      = WIDE_W'(unp_i.sig) << INT_W;
    e_i       = int'(unp_i.exp);
    shifted   = '0;
    tiny      = 1'b0;
    too_big_o = 1'b0;
    if (e_i > INT_W - 1) begin
      too_big_o = 1'b1;
    end else if (e_i >= SIG_POINT) begin
      shifted = wide << (e_i - SIG_POINT);
    end else if (e_i >= -1) begin
      shifted = wide >> (SIG_POINT - e_i);
    end else begin
      tiny = 1'b1;
    end
    int_o = shifted[WIDE_W-1:INT_W];
    rnd_o = shifted[INT_W-1];
    stk_o = tiny ? unp_i.nonzero : (|shifted[INT_W-2:0]);
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic             sign_i,
  input  rmode_e           mode_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             rnd_i,
  input  logic             stk_i,
  output logic [INT_W:0]   mag_o,
  output logic             lost_o
);
  logic inc;

  always_comb begin
    lost_o = rnd_i | stk_i;
    unique case (mode_i)
      RM_NEAR: inc = rnd_i & (stk_i | int_i[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sign_i & lost_o;
      RM_DOWN: inc = sign_i & lost_o;
      default: inc = 1'b0;
    endcase
    mag_o = {1'b0, int_i} + (INT_W+1)'(inc);
  end
endmodule

// File: rtl/fcvt_pack.sv
module fcvt_pack
  import fcvt_pkg::*;
(
  input  logic             sign_i,
  input  logic             special_i,
  input  logic             too_big_i,
  input  logic [INT_W:0]   mag_i,
  input  logic             lost_i,
  input  logic             to_long_i,
  output logic [INT_W-1:0] result_o,
  output logic             ovf_o,
  output logic             inv_o,
  output logic             inx_o
);
  localparam logic [INT_W:0] LONG_NEG = (INT_W+1)'(1) << (INT_W - 1);
  localparam logic [INT_W:0] LONG_POS = LONG_NEG - 1'b1;
  localparam logic [INT_W:0] WORD_NEG = (INT_W+1)'(1) << (WORD_W - 1);
  localparam logic [INT_W:0] WORD_POS = WORD_NEG - 1'b1;
  localparam logic [INT_W-1:0] LONG_DFLT = LONG_POS[INT_W-1:0];
  localparam logic [INT_W-1:0] WORD_DFLT = WORD_POS[INT_W-1:0];

  logic [INT_W:0]   limit;
  logic [INT_W-1:0] signed_val;
  logic [INT_W-1:0] word_val;

  always_comb begin
    if (to_long_i) limit = sign_i ? LONG_NEG : LONG_POS;
    else           limit = sign_i ? WORD_NEG : WORD_POS;
    signed_val = sign_i ? (~mag_i[INT_W-1:0] + 1'b1) : mag_i[INT_W-1:0];
    word_val   = {{(INT_W-WORD_W){signed_val[WORD_W-1]}}, signed_val[WORD_W-1:0]};
    inv_o = special_i;
    ovf_o = ~special_i & (too_big_i | (mag_i > limit));
    inx_o = lost_i & ~inv_o & ~ovf_o;
    if (inv_o | ovf_o) result_o = to_long_i ? LONG_DFLT : WORD_DFLT;
    else               result_o = to_long_i ? signed_val : word_val;
  end
endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
  import fcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_operand,
  input  logic        in_is_double,
  input  logic        in_to_long,
  input  logic [1:0]  in_mode,
  output logic [63:0] out_result,
  output logic        out_overflow,
  output logic        out_invalid,
  output logic        out_inexact,
  output logic        out_done
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  unpacked_t unp [N_FMT];

  for (genvar f = 0; f < N_FMT; f++) begin : g_fmt
    localparam int EW = (f == 0) ? SGL_EXP  : DBL_EXP;
    localparam int FW = (f == 0) ? SGL_FRAC : DBL_FRAC;
    fcvt_unpack #(.EXP_BITS(EW), .FRAC_BITS(FW)) u_unpack (
      .bits_i (in_operand[EW+FW:0]),
      .unp_o  (unp[f])
    );
  end

  unpacked_t        sel;
  logic [INT_W-1:0] int_part;
  logic             rnd, stk, too_big, lost;
  logic [INT_W:0]   mag;
  logic [INT_W-1:0] res_c;
  logic             ovf_c, inv_c, inx_c;

  assign sel = in_is_double ? unp[1] : unp[0];

  fcvt_align u_align (
    .unp_i     (sel),
    .int_o     (int_part),
    .rnd_o     (rnd),
    .stk_o     (stk),
    .too_big_o (too_big)
  );

  fcvt_round u_round (
    .sign_i (sel.sign),
    .mode_i (rmode_e'(in_mode)),
    .int_i  (int_part),
    .rnd_i  (rnd),
    .stk_i  (stk),
    .mag_o  (mag),
    .lost_o (lost)
  );

  fcvt_pack u_pack (
    .sign_i    (sel.sign),
    .special_i (sel.special),
    .too_big_i (too_big),
    .mag_i     (mag),
    .lost_i    (lost),
    .to_long_i (in_to_long),
    .result_o  (res_c),
    .ovf_o     (ovf_c),
    .inv_o     (inv_c),
    .inx_o     (inx_c)
  );

  logic [INT_W-1:0] res_d, res_q;
  logic [2:0]       flg_d, flg_q;
  logic             done_d, done_q;

  always_comb begin
    res_d  = res_q;
    flg_d  = flg_q;
    done_d = in_valid;
    if (in_valid) begin
      res_d = res_c;
      flg_d = {ovf_c, inv_c, inx_c};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  assign out_result   = res_q;
  assign out_overflow = flg_q[2];
  assign out_invalid  = flg_q[1];
  assign out_inexact  = flg_q[0];
  assign out_done     = done_q;
endmodule

// File: rtl/fcvt_unit_checker.sv
module fcvt_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_operand,
  input logic        in_is_double,
  input logic        in_to_long,
  input logic [63:0] out_result,
  input logic        out_overflow,
  input logic        out_invalid,
  input logic        out_inexact,
  input logic        out_done
);
  logic src_special;
  assign src_special = in_is_double ? (&in_operand[62:52]) : (&in_operand[30:23]);

  // R9
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  // R6
  invalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_invalid == $past(src_special)));
  // R7
  word_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_to_long) |=> (!(out_overflow || out_invalid) || out_result == 64'h0000_0000_7FFF_FFFF));
  // R7
  long_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_to_long) |=> (!(out_overflow || out_invalid) || out_result == 64'h7FFF_FFFF_FFFF_FFFF));
  // R8
  inexact_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !(out_inexact && (out_overflow || out_invalid)));
  // R5
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_to_long) |=> (out_result[63:32] == {32{out_result[31]}}));
endmodule

bind fcvt_unit fcvt_unit_checker chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_operand   (in_operand),
  .in_is_double (in_is_double),
  .in_to_long   (in_to_long),
  .out_result   (out_result),
  .out_overflow (out_overflow),
  .out_invalid  (out_invalid),
  .out_inexact  (out_inexact),
  .out_done     (out_done)
);

// File: tb/fcvt_unit_test.sv
module fcvt_unit_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_operand;
  logic        in_is_double;
  logic        in_to_long;
  logic [1:0]  in_mode;
  logic [63:0] out_result;
  logic        out_overflow, out_invalid, out_inexact, out_done;

  int checks = 0;
  int errors = 0;

  fcvt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_is_double(in_is_double), .in_to_long(in_to_long), .in_mode(in_mode),
    .out_result(out_result), .out_overflow(out_overflow), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_done(out_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [63:0] WDEF = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] LDEF = 64'h7FFF_FFFF_FFFF_FFFF;

  function automatic logic [31:0] to_single(logic [63:0] d);
    logic [10:0] e;
    if (d[62:0] == 63'd0) return {d[63], 31'd0};
    e = d[62:52] - 11'd896;
    return {d[63], e[7:0], d[51:29]};
  endfunction

  function automatic longint floor4(longint k);
    if (k >= 0) return k / 4;
    return -((-k + 3) / 4);
  endfunction

  task automatic check(string tag, logic [63:0] act_r, logic [63:0] exp_r,
                       logic [3:0] act_f, logic [3:0] exp_f);
    checks++;
    if (act_r !== exp_r || act_f !== exp_f) begin
      errors++;
      $display("FAIL %s result=%h done/ovf/inv/inx=%b expected result=%h done/ovf/inv/inx=%b",
               tag, act_r, act_f, exp_r, exp_f);
    end
  endtask

  task automatic run(string tag, logic [63:0] op, logic dbl, logic lng, logic [1:0] md,
                     logic [63:0] er, logic [2:0] ef);
    @(negedge clk);
    in_operand   = op;
    in_is_double = dbl;
    in_to_long   = lng;
    in_mode      = md;
    in_valid     = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_result, er, {out_done, out_overflow, out_invalid, out_inexact}, {1'b1, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired result=%h expected done", out_result);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d, op, ev;
    longint      fl, r, v;
    string       tg;

    rst_n = 1'b0; in_valid = 1'b0; in_operand = '0;
    in_is_double = 1'b0; in_to_long = 1'b0; in_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", out_result, 64'd0, {out_done, out_overflow, out_invalid, out_inexact}, 4'b0000);

    // Sweep of quarter steps, all modes, formats and widths (R1..R5, R8)
    for (int k = -64; k <= 64; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int f = 0; f < 2; f++) begin
          for (int w = 0; w < 2; w++) begin
            d  = $realtobits(real'(k) / 4.0);
            op = (f == 1) ? d : {32'hDEAD_BEEF, to_single(d)};
            fl = floor4(longint'(k));
            r  = longint'(k) - 4 * fl;
            case (m)
              0: begin v = fl + (((r == 3) || (r == 2 && fl[0])) ? 1 : 0); tg = "R1"; end
              1: begin v = longint'(k) / 4; tg = "R2"; end
              2: begin v = (r == 0) ? fl : fl + 1; tg = "R3"; end
              default: begin v = fl; tg = "R4"; end
            endcase
            run(tg, op, f[0], w[0], m[1:0], 64'(v), {2'b00, r != 0});
          end
        end
      end
    end

    // R6 NaN and infinity
    run("R6", 64'h7FF8_0000_0000_0000, 1'b1, 1'b1, 2'd0, LDEF, 3'b010);
    run("R6", 64'h0000_0000_7FC0_0000, 1'b0, 1'b0, 2'd1, WDEF, 3'b010);
    run("R6", 64'hFFF0_0000_0000_0000, 1'b1, 1'b0, 2'd3, WDEF, 3'b010);
    run("R6", 64'h0000_0000_FF80_0000, 1'b0, 1'b1, 2'd2, LDEF, 3'b010);

    // R7 range limits
    run("R7", 64'h41E0_0000_0000_0000, 1'b1, 1'b0, 2'd1, WDEF, 3'b100);
    run("R5", 64'h41E0_0000_0000_0000, 1'b1, 1'b1, 2'd1, 64'h0000_0000_8000_0000, 3'b000);
    run("R7", 64'hC1E0_0000_0000_0000, 1'b1, 1'b0, 2'd1, 64'hFFFF_FFFF_8000_0000, 3'b000);
    run("R1", $realtobits(-2147483648.5), 1'b1, 1'b0, 2'd0, 64'hFFFF_FFFF_8000_0000, 3'b001);
    run("R7", $realtobits(-2147483648.5), 1'b1, 1'b0, 2'd3, WDEF, 3'b100);
    run("R7", $realtobits(2147483647.5), 1'b1, 1'b0, 2'd0, WDEF, 3'b100);
    run("R2", $realtobits(2147483647.5), 1'b1, 1'b0, 2'd1, 64'h0000_0000_7FFF_FFFF, 3'b001);
    run("R7", 64'h43E0_0000_0000_0000, 1'b1, 1'b1, 2'd2, LDEF, 3'b100);
    run("R7", 64'hC3E0_0000_0000_0000, 1'b1, 1'b1, 2'd3, 64'h8000_0000_0000_0000, 3'b000);
    run("R5", 64'h43DF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'd1, 64'h7FFF_FFFF_FFFF_FC00, 3'b000);
    run("R5", 64'h4330_0000_0000_0001, 1'b1, 1'b1, 2'd0, 64'h0010_0000_0000_0001, 3'b000);
    run("R7", {32'd0, to_single($realtobits(-1.0e30))}, 1'b0, 1'b1, 2'd0, LDEF, 3'b100);

    // R10 zeros and subnormals
    run("R10", 64'h8000_0000_0000_0000, 1'b1, 1'b1, 2'd3, 64'd0, 3'b000);
    run("R10", 64'h0000_0000_0000_0001, 1'b1, 1'b1, 2'd2, 64'd1, 3'b001);
    run("R10", 64'h0000_0000_0000_0001, 1'b1, 1'b1, 2'd0, 64'd0, 3'b001);
    run("R10", 64'h0000_0000_0000_0001, 1'b1, 1'b0, 2'd1, 64'd0, 3'b001);
    run("R10", 64'h8000_0000_0000_0001, 1'b1, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
    run("R10", 64'h8000_0000_0000_0001, 1'b1, 1'b1, 2'd2, 64'd0, 3'b001);
    run("R10", 64'h0000_0000_0000_0001, 1'b0, 1'b0, 2'd2, 64'd1, 3'b001);
    run("R10", 64'h0000_0000_8000_0001, 1'b0, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
    run("R1", 64'h0000_0000_C020_0000, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001);

    // R9 hold while idle
    ev = 64'hFFFF_FFFF_FFFF_FFFE;
    in_operand = 64'h4000_0000_0000_0000;
    in_mode    = 2'd2;
    repeat (3) @(negedge clk);
    check("R9", out_result, ev, {out_done, out_overflow, out_invalid, out_inexact}, 4'b0001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule